// File: doc/BRIEF.md
# Bulk IN Endpoint Transmit Controller

This block is the transmit half of a single bulk IN endpoint inside a USB device controller. Software pushes data bytes into a two-slot packet queue and steers the endpoint through one 32-bit control/status word. The serial engine answers each IN token from the head of the queue. Slots are counted as whole packets. A slot closes either when its 64th byte arrives or when software issues a short-packet command. A short-packet command with no bytes loaded queues a zero-length packet.

The engine side receives a registered response one cycle after each token: data with its length, NAK when nothing is queued, or STALL while software forces a stall. The engine then pulls bytes one at a time. A host acknowledgement retires the head packet and raises the packet-complete flag. Without an acknowledgement, the next token presents the same packet again from its first byte. An interrupt request follows the packet-complete flag under an enable input.

Top module: `ep_bulk_in_tx`

## Requirements
- R1: After reset the status word reads 0x00000001 (only the room flag set), `irq` is 0 and `resp_valid` is 0.
- R2: A packet is committed when its 64th byte is written, or by writing 1 to bit 7 of the status word; the committed length equals the bytes loaded, and 0 bytes gives a zero-length packet.
- R3: Bit 0 (room) reads 1 while fewer than two packets are committed and 0 while two are; it returns to 1 in the cycle after a packet is retired.
- R4: While two packets are committed, data writes and short-packet commands are ignored and leave no trace in later packets.
- R5: Every `eng_tok` pulse is answered one cycle later by `resp_valid`=1 with `resp_kind` DATA (2'b01) with `resp_len` equal to the head packet length, NAK (2'b10) with length 0 when nothing is committed, or STALL (2'b11) with length 0; without a token `resp_valid` is 0.
- R6: `eng_rdata` shows the head packet byte at the current read position, each `eng_rd` pulse advances it, and each token restarts it at byte 0 so an unacknowledged packet is resent unchanged.
- R7: `eng_ack` with a packet queued retires the head packet and sets bit 1 (packet complete) in the next cycle; bit 1 stays set until a write with bit 1 = 1.
- R8: Bit 5 (force stall) is read/write; while it is 1, tokens get STALL and bit 4 (stall sent) sets together with the response; bit 4 clears on a write with bit 4 = 1; queued packets are untouched.
- R9: Bit 3 (underrun) sets one cycle after `eng_rd` at or beyond the head packet length or with nothing queued; it clears on a write with bit 3 = 1.
- R10: Writing 1 to bit 2 discards all committed packets and any partly loaded bytes.
- R11: Bits 2 and 7 always read 0, as do reserved bits 6 and 31:8.
- R12: `irq` rises in the cycle after a packet-complete set that occurs while `irq_en` is 1, stays high through any change of `irq_en` until bit 1 is cleared, and is not raised when `irq_en` becomes 1 after the set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_dat_we | input | 1 | Data byte write strobe |
| cpu_dat | input | 8 | Data byte |
| csr_we | input | 1 | Status word write strobe |
| csr_wdata | input | 32 | Status word write value |
| csr_rdata | output | 32 | Status word read value |
| irq_en | input | 1 | Transmit interrupt enable |
| irq | output | 1 | Interrupt request |
| eng_tok | input | 1 | IN token received, one-cycle pulse |
| eng_rd | input | 1 | Byte consumed by the engine |
| eng_ack | input | 1 | Host acknowledged the packet |
| eng_rdata | output | 8 | Byte at the read position |
| resp_valid | output | 1 | Token response valid |
| resp_kind | output | 2 | Response type: 01 DATA, 10 NAK, 11 STALL |
| resp_len | output | 7 | Packet length of a DATA response |

## Verification
Every flag and the queue count change at the clock edge where the triggering strobe is sampled. Status bits and `irq` are therefore due one cycle after the stimulus, and the token response is due one cycle after `eng_tok`. `eng_rdata` is combinational from the read position, so a byte is due in the same cycle that the position settles. The bench drives inputs on the falling edge and removes them one full cycle later. It samples on that later falling edge, which lands exactly one register stage after the stimulus. Byte data is sampled on the falling edge before each `eng_rd` pulse.

// File: rtl/ep_tx_pkg.sv
package ep_tx_pkg;

  typedef enum logic [1:0] {
    RESP_NONE  = 2'b00,
    RESP_DATA  = 2'b01,
    RESP_NAK   = 2'b10,
    RESP_STALL = 2'b11
  } resp_e;

  localparam int B_ROOM  = 0;
  localparam int B_DONE  = 1;
  localparam int B_FLUSH = 2;
  localparam int B_UNDR  = 3;
  localparam int B_SSENT = 4;
  localparam int B_FSTL  = 5;
  localparam int B_SHORT = 7;

  // status image, strobe bits and reserved bits read as zero
  function automatic logic [7:0] status_byte(input logic room, input logic done,
                                             input logic undr, input logic ssent,
                                             input logic fstl);
    logic [7:0] s;
    s = '0;
    s[B_ROOM]  = room;
    s[B_DONE]  = done;
    s[B_UNDR]  = undr;
    s[B_SSENT] = ssent;
    s[B_FSTL]  = fstl;
    return s;
  endfunction

  // answer chosen for an IN token
  function automatic resp_e resp_pick(input logic fstl, input logic have_pkt);
    if (fstl) return RESP_STALL;
    if (!have_pkt) return RESP_NAK;
    return RESP_DATA;
  endfunction

endpackage

// File: rtl/ep_tx_store.sv
module ep_tx_store #(
  parameter int SLOTS     = 2,
  parameter int PKT_BYTES = 64,
  parameter int SLOT_W    = $clog2(SLOTS),
  parameter int IDX_W     = $clog2(PKT_BYTES),
  parameter int LEN_W     = $clog2(PKT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [7:0]        wr_data,
  input  logic              len_we,
  input  logic [LEN_W-1:0]  len_val,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [7:0]        rd_data,
  output logic [LEN_W-1:0]  rd_len
);

  logic [SLOTS-1:0][7:0]       slot_byte;
  logic [SLOTS-1:0][LEN_W-1:0] slot_len;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [7:0]       mem [PKT_BYTES];
    logic [LEN_W-1:0] len_q;
    logic             hit_w;

    assign hit_w = (wr_slot == SLOT_W'(s));

    always_ff @(posedge clk) begin
      if (wr_en && hit_w) mem[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               len_q <= '0;
      else if (len_we && hit_w) len_q <= len_val;
    end

    assign slot_byte[s] = mem[rd_idx];
    assign slot_len[s]  = len_q;
  end

  assign rd_data = slot_byte[rd_slot];
  assign rd_len  = slot_len[rd_slot];

endmodule

// File: rtl/ep_tx_fifo_ctrl.sv
module ep_tx_fifo_ctrl #(
  parameter int SLOTS     = 2,
  parameter int PKT_BYTES = 64,
  parameter int SLOT_W    = $clog2(SLOTS),
  parameter int IDX_W     = $clog2(PKT_BYTES),
  parameter int LEN_W     = $clog2(PKT_BYTES + 1),
  parameter int CNT_W     = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_we,
  input  logic              short_cmd,
  input  logic              flush_cmd,
  input  logic              tok_data,
  input  logic              rd_req,
  input  logic              ack,
  input  logic [LEN_W-1:0]  head_len,
  output logic [SLOT_W-1:0] head_slot,
  output logic [SLOT_W-1:0] tail_slot,
  output logic [IDX_W-1:0]  fill_idx,
  output logic [IDX_W-1:0]  rd_addr,
  output logic              store_we,
  output logic              commit,
  output logic [LEN_W-1:0]  commit_len,
  output logic [CNT_W-1:0]  q_count,
  output logic              pop,
  output logic              underrun_evt,
  output logic              room
);

  localparam logic [CNT_W-1:0]  SLOTS_C   = CNT_W'(SLOTS);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(PKT_BYTES - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  function automatic logic [SLOT_W-1:0] ring_next(input logic [SLOT_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] count_next(input logic [CNT_W-1:0] c,
                                                  input logic up, input logic dn);
    return c + CNT_W'(up) - CNT_W'(dn);
  endfunction

  logic [LEN_W-1:0] rd_pos;
  logic             have_pkt;
  logic             byte_ok;
  logic             full_hit;
  logic             short_ok;
  logic             rd_step;

  assign room       = (q_count < SLOTS_C);
  assign have_pkt   = (q_count != '0);
  assign byte_ok    = byte_we && room && !flush_cmd;
  assign full_hit   = byte_ok && (fill_idx == LAST_IDX);
  assign short_ok   = short_cmd && room && !flush_cmd && !full_hit;
  assign commit     = full_hit || short_ok;
  assign commit_len = LEN_W'(fill_idx) + LEN_W'(byte_ok);
  assign store_we   = byte_ok;
  assign pop        = ack && have_pkt && !flush_cmd;
  assign rd_step    = rd_req && have_pkt && (rd_pos < head_len);
  assign underrun_evt = rd_req && !rd_step && !flush_cmd;
  assign rd_addr    = rd_pos[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_slot <= '0;
      tail_slot <= '0;
      fill_idx  <= '0;
      q_count   <= '0;
      rd_pos    <= '0;
    end else if (flush_cmd) begin
      head_slot <= '0;
      tail_slot <= '0;
      fill_idx  <= '0;
      q_count   <= '0;
      rd_pos    <= '0;
    end else begin
      if (commit)       fill_idx <= '0;
      else if (byte_ok) fill_idx <= fill_idx + 1'b1;
      if (commit) tail_slot <= ring_next(tail_slot);
      if (pop)    head_slot <= ring_next(head_slot);
      q_count <= count_next(q_count, commit, pop);
      if (pop || tok_data) rd_pos <= '0;
      else if (rd_step)    rd_pos <= rd_pos + 1'b1;
    end
  end

endmodule

// File: rtl/ep_tx_csr.sv
module ep_tx_csr
  import ep_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  input  logic        room,
  input  logic        done_set,
  input  logic        undr_set,
  input  logic        ssent_set,
  input  logic        irq_en,
  output logic [31:0] rdata,
  output logic        fstl,
  output logic        flush_cmd,
  output logic        short_cmd,
  output logic        irq
);

  logic done_q, undr_q, ssent_q;
  logic done_clr, undr_clr, ssent_clr;
  logic unused_bits;

  assign done_clr  = we && wdata[B_DONE];
  assign undr_clr  = we && wdata[B_UNDR];
  assign ssent_clr = we && wdata[B_SSENT];
  assign flush_cmd = we && wdata[B_FLUSH];
  assign short_cmd = we && wdata[B_SHORT];
  assign unused_bits = ^{wdata[31:8], wdata[6], wdata[B_ROOM]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      undr_q  <= 1'b0;
      ssent_q <= 1'b0;
      fstl    <= 1'b0;
      irq     <= 1'b0;
    end else begin
      done_q  <= done_set  || (done_q  && !done_clr);
      undr_q  <= undr_set  || (undr_q  && !undr_clr);
      ssent_q <= ssent_set || (ssent_q && !ssent_clr);
      if (we) fstl <= wdata[B_FSTL];
      if (done_set && irq_en) irq <= 1'b1;
      else if (done_clr)      irq <= 1'b0;
    end
  end

  assign rdata = {24'b0, status_byte(room, done_q, undr_q, ssent_q, fstl)};

endmodule

// File: rtl/ep_bulk_in_tx.sv
module ep_bulk_in_tx
  import ep_tx_pkg::*;
#(
  parameter int SLOTS     = 2,
  parameter int PKT_BYTES = 64
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cpu_dat_we,
  input  logic [7:0]                         cpu_dat,
  input  logic                               csr_we,
  input  logic [31:0]                        csr_wdata,
  output logic [31:0]                        csr_rdata,
  input  logic                               irq_en,
  output logic                               irq,
  input  logic                               eng_tok,
  input  logic                               eng_rd,
  input  logic                               eng_ack,
  output logic [7:0]                         eng_rdata,
  output logic                               resp_valid,
  output logic [1:0]                         resp_kind,
  output logic [$clog2(PKT_BYTES + 1)-1:0]   resp_len
);

  localparam int SLOT_W = $clog2(SLOTS);
  localparam int IDX_W  = $clog2(PKT_BYTES);
  localparam int LEN_W  = $clog2(PKT_BYTES + 1);
  localparam int CNT_W  = $clog2(SLOTS + 1);

  logic [SLOT_W-1:0] head_slot, tail_slot;
  logic [IDX_W-1:0]  fill_idx, rd_addr;
  logic [LEN_W-1:0]  head_len, commit_len;
  logic [CNT_W-1:0]  q_count;
  logic              store_we, commit, ack_pop, underrun_evt, room;
  logic              fstl, flush_cmd, short_cmd;
  logic              have_pkt, tok_data, stall_out;
  resp_e             pick;

  assign have_pkt  = (q_count != '0);
  assign pick      = resp_pick(fstl, have_pkt);
  assign tok_data  = eng_tok && (pick == RESP_DATA);
  assign stall_out = eng_tok && (pick == RESP_STALL);

  ep_tx_store #(
    .SLOTS(SLOTS), .PKT_BYTES(PKT_BYTES),
    .SLOT_W(SLOT_W), .IDX_W(IDX_W), .LEN_W(LEN_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(store_we), .wr_slot(tail_slot), .wr_idx(fill_idx), .wr_data(cpu_dat),
    .len_we(commit), .len_val(commit_len),
    .rd_slot(head_slot), .rd_idx(rd_addr), .rd_data(eng_rdata), .rd_len(head_len)
  );

  ep_tx_fifo_ctrl #(
    .SLOTS(SLOTS), .PKT_BYTES(PKT_BYTES),
    .SLOT_W(SLOT_W), .IDX_W(IDX_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .byte_we(cpu_dat_we), .short_cmd(short_cmd), .flush_cmd(flush_cmd),
    .tok_data(tok_data), .rd_req(eng_rd), .ack(eng_ack), .head_len(head_len),
    .head_slot(head_slot), .tail_slot(tail_slot), .fill_idx(fill_idx),
    .rd_addr(rd_addr), .store_we(store_we), .commit(commit),
    .commit_len(commit_len), .q_count(q_count), .pop(ack_pop),
    .underrun_evt(underrun_evt), .room(room)
  );

  ep_tx_csr u_csr (
    .clk(clk), .rst_n(rst_n),
    .we(csr_we), .wdata(csr_wdata), .room(room),
    .done_set(ack_pop), .undr_set(underrun_evt), .ssent_set(stall_out),
    .irq_en(irq_en), .rdata(csr_rdata), .fstl(fstl),
    .flush_cmd(flush_cmd), .short_cmd(short_cmd), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_kind  <= RESP_NONE;
      resp_len   <= '0;
    end else begin
      resp_valid <= eng_tok;
      resp_kind  <= eng_tok ? pick : RESP_NONE;
      resp_len   <= tok_data ? head_len : '0;
    end
  end

endmodule

// File: rtl/ep_bulk_in_tx_chk.sv
module ep_bulk_in_tx_chk #(
  parameter int SLOTS = 2,
  parameter int CNT_W = $clog2(SLOTS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             csr_we,
  input logic [31:0]      csr_wdata,
  input logic [31:0]      csr_rdata,
  input logic             irq,
  input logic             eng_tok,
  input logic             eng_rd,
  input logic             resp_valid,
  input logic [1:0]       resp_kind,
  input logic             ack_pop,
  input logic [CNT_W-1:0] q_count
);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(SLOTS));

  // R3
  room_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pop |=> csr_rdata[0]);

  // R5
  resp_follows_tok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_tok |=> resp_valid);

  // R5
  resp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_tok |=> !resp_valid);

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[1] && !(csr_we && csr_wdata[1]) |=> csr_rdata[1]);

  // R8
  stall_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_tok && csr_rdata[5] && !csr_we |=> (resp_kind == 2'b11) && csr_rdata[4]);

  // R9
  underrun_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rd && (q_count == '0) && !csr_we |=> csr_rdata[3]);

  // R11
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata[31:8] == 24'b0) && !csr_rdata[7] && !csr_rdata[6] && !csr_rdata[2]);

  // R12
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !(csr_we && csr_wdata[1]) |=> irq);

  // R12
  irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> csr_rdata[1]);

endmodule

bind ep_bulk_in_tx ep_bulk_in_tx_chk #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
  .csr_rdata(csr_rdata), .irq(irq), .eng_tok(eng_tok), .eng_rd(eng_rd),
  .resp_valid(resp_valid), .resp_kind(resp_kind), .ack_pop(ack_pop),
  .q_count(q_count)
);

// File: tb/ep_bulk_in_tx_tb.sv
`timescale 1ns/1ps
module ep_bulk_in_tx_tb;

  localparam logic [1:0] K_DATA = 2'b01, K_NAK = 2'b10, K_STALL = 2'b11;

  typedef struct packed {
    logic [7:0] nbytes;
    logic       shortc;
    logic [7:0] seed;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{8'd64, 1'b0, 8'h3C},
    '{8'd1,  1'b1, 8'hA5},
    '{8'd0,  1'b1, 8'h00},
    '{8'd63, 1'b1, 8'h5A},
    '{8'd17, 1'b1, 8'hC3},
    '{8'd40, 1'b1, 8'h0F}
  };

  logic        clk = 0, rst_n = 0;
  logic        cpu_dat_we = 0, csr_we = 0, irq_en = 0;
  logic        eng_tok = 0, eng_rd = 0, eng_ack = 0;
  logic [7:0]  cpu_dat = 0;
  logic [31:0] csr_wdata = 0;
  logic [31:0] csr_rdata;
  logic        irq, resp_valid;
  logic [1:0]  resp_kind;
  logic [6:0]  resp_len;
  logic [7:0]  eng_rdata;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  ep_bulk_in_tx u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_dat_we(cpu_dat_we), .cpu_dat(cpu_dat),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .irq_en(irq_en), .irq(irq), .eng_tok(eng_tok), .eng_rd(eng_rd),
    .eng_ack(eng_ack), .eng_rdata(eng_rdata), .resp_valid(resp_valid),
    .resp_kind(resp_kind), .resp_len(resp_len)
  );

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed ^ 8'(i * 7);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    cpu_dat_we = 1; cpu_dat = b;
    @(negedge clk);
    cpu_dat_we = 0;
  endtask

  task automatic load(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) put_byte(pat(seed, i));
  endtask

  task automatic csr_w(input logic [31:0] v);
    csr_we = 1; csr_wdata = v;
    @(negedge clk);
    csr_we = 0; csr_wdata = 0;
  endtask

  task automatic tok_chk(input string req, input logic [1:0] kind, input int len);
    eng_tok = 1;
    @(negedge clk);
    eng_tok = 0;
    chk(req, {31'b0, resp_valid}, 32'd1);
    chk(req, {30'b0, resp_kind}, {30'b0, kind});
    chk(req, {25'b0, resp_len}, 32'(len));
  endtask

  task automatic rd_chk(input string req, input logic [7:0] exp);
    chk(req, {24'b0, eng_rdata}, {24'b0, exp});
    eng_rd = 1;
    @(negedge clk);
    eng_rd = 0;
  endtask

  task automatic ack;
    eng_ack = 1;
    @(negedge clk);
    eng_ack = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 csr", csr_rdata, 32'h1);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 resp", {31'b0, resp_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R5 idle", {31'b0, resp_valid}, 0);

    // table of packet shapes: R2 R5 R6 R7
    for (int v = 0; v < 6; v++) begin
      load(int'(VEC[v].nbytes), VEC[v].seed);
      if (VEC[v].shortc) begin
        csr_w(32'h80);
        chk("R11 short reads 0", {31'b0, csr_rdata[7]}, 0);
      end
      chk("R3 room one queued", {31'b0, csr_rdata[0]}, 1);
      tok_chk("R2 R5 data len", K_DATA, int'(VEC[v].nbytes));
      for (int i = 0; i < int'(VEC[v].nbytes); i++)
        rd_chk("R6 byte", pat(VEC[v].seed, i));
      ack();
      chk("R7 done set", {31'b0, csr_rdata[1]}, 1);
      @(negedge clk);
      chk("R7 done sticky", {31'b0, csr_rdata[1]}, 1);
      csr_w(32'h02);
      chk("R7 done cleared", {31'b0, csr_rdata[1]}, 0);
    end

    // R3 R4 two queued, extra writes ignored
    load(64, 8'h11);
    chk("R3 room after one", {31'b0, csr_rdata[0]}, 1);
    load(64, 8'h22);
    chk("R3 full", {31'b0, csr_rdata[0]}, 0);
    put_byte(8'hEE);
    csr_w(32'h80);
    chk("R3 still full", {31'b0, csr_rdata[0]}, 0);
    tok_chk("R4 first pkt", K_DATA, 64);
    rd_chk("R4 first byte", pat(8'h11, 0));
    ack();
    chk("R3 room after pop", {31'b0, csr_rdata[0]}, 1);
    tok_chk("R4 second pkt", K_DATA, 64);
    rd_chk("R4 second byte0", pat(8'h22, 0));
    rd_chk("R4 second byte1", pat(8'h22, 1));
    ack();
    tok_chk("R4 nothing left", K_NAK, 0);
    csr_w(32'h02);

    // R6 retry without ack
    load(3, 8'h77);
    csr_w(32'h80);
    tok_chk("R6 first try", K_DATA, 3);
    rd_chk("R6 try b0", pat(8'h77, 0));
    rd_chk("R6 try b1", pat(8'h77, 1));
    tok_chk("R6 retry", K_DATA, 3);
    for (int i = 0; i < 3; i++) rd_chk("R6 retry byte", pat(8'h77, i));
    ack();
    csr_w(32'h02);

    // R9 underrun on zero-length packet
    csr_w(32'h80);
    tok_chk("R2 zlp", K_DATA, 0);
    chk("R9 no underrun yet", {31'b0, csr_rdata[3]}, 0);
    eng_rd = 1; @(negedge clk); eng_rd = 0;
    chk("R9 underrun set", {31'b0, csr_rdata[3]}, 1);
    csr_w(32'h08);
    chk("R9 underrun clr", {31'b0, csr_rdata[3]}, 0);
    ack();
    csr_w(32'h02);

    // R8 stall with a packet queued
    load(5, 8'h99);
    csr_w(32'h80);
    csr_w(32'h20);
    chk("R8 fst reads", {31'b0, csr_rdata[5]}, 1);
    tok_chk("R8 stall", K_STALL, 0);
    chk("R8 sent set", {31'b0, csr_rdata[4]}, 1);
    csr_w(32'h30);
    chk("R8 sent clr", {31'b0, csr_rdata[4]}, 0);
    chk("R8 fst kept", {31'b0, csr_rdata[5]}, 1);
    csr_w(32'h00);
    tok_chk("R8 pkt kept", K_DATA, 5);
    rd_chk("R8 pkt byte", pat(8'h99, 0));
    ack();
    csr_w(32'h02);

    // R10 flush full queue and partial
    load(10, 8'h44);
    csr_w(32'h80);
    load(64, 8'h55);
    chk("R3 full before flush", {31'b0, csr_rdata[0]}, 0);
    load(3, 8'h66);
    csr_w(32'h04);
    chk("R10 R11 csr after flush", csr_rdata, 32'h1);
    tok_chk("R10 emptied", K_NAK, 0);
    csr_w(32'h80);
    tok_chk("R10 partial dropped", K_DATA, 0);
    ack();
    csr_w(32'h02);

    // R12 interrupt
    irq_en = 1;
    csr_w(32'h80);
    ack();
    chk("R12 irq up", {31'b0, irq}, 1);
    irq_en = 0; @(negedge clk);
    chk("R12 irq held en low", {31'b0, irq}, 1);
    irq_en = 1; @(negedge clk);
    chk("R12 irq held en high", {31'b0, irq}, 1);
    csr_w(32'h02);
    chk("R12 irq cleared", {31'b0, irq}, 0);
    irq_en = 0;
    csr_w(32'h80);
    ack();
    chk("R12 done no irq", {31'b0, csr_rdata[1]}, 1);
    chk("R12 irq off", {31'b0, irq}, 0);
    irq_en = 1; @(negedge clk);
    chk("R12 late enable", {31'b0, irq}, 0);
    csr_w(32'h02);
    chk("R11 reserved", {24'b0, csr_rdata[7:6], 6'b0}, 0);
    chk("R11 upper", csr_rdata & 32'hFFFF_FF00, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule